// File: doc/BRIEF.md
# Byte-Wide CRC-16 Accumulator

This block keeps a running 16-bit checksum and folds one byte into it for every byte it accepts. Each byte is first XORed into the high eight bits of the checksum. Then eight left-shift steps run, most significant bit first. A step whose outgoing top bit is set also XORs in the generator 0x1021. The checksum can be seeded to all-zeros or all-ones at any time, and the current value is always visible on the result output.

Bytes arrive on a valid/ready stream. A byte is taken on a rising clock edge where `in_valid` and `in_ready` are both high. The producer must hold `in_valid` and `in_data` steady until that edge. `in_ready` is low in two cases: while `init` is high, and (in the bit-serial variant) while the engine is busy. A byte offered during those cycles waits and is not lost.

The parameter `SERIAL` picks the variant. With `SERIAL=1` the engine processes one bit per clock, so a byte takes eight cycles. With `SERIAL=0` it folds a whole byte in a single clock and is never busy. The seed, initialise and reset controls are plain pins.

Top module: `crc16_accum`

## Requirements
- R1: A synchronous active-high `rst` sets the checksum to 0xFFFF and clears `busy`. In the first cycle after reset, `in_ready` is high.
- R2: When `init` is high at a clock edge, the checksum becomes 0xFFFF if `init_seed_ones` is 1, or 0x0000 if it is 0. While `init` is high, `in_ready` is low, so no byte is taken in that cycle.
- R3: An accepted byte updates the checksum in two stages. First the byte is XORed into bits 15:8. Then exactly eight steps run, each a left shift by one followed by an XOR with 0x1021 whenever bit 15 was 1 before that shift.
- R4: Starting from seed 0xFFFF, the expected results are:
  - byte 0x63 gives 0xBD35;
  - bytes 0xAA, 0xBB, 0xCC give 0x6CF6;
  - bytes 0x00, 0x00, 0xAA, 0xBB, 0xCC give 0xB166.
- R5: In the bit-serial variant, `busy` is high for exactly the 8 cycles after an accepted byte, and `in_ready` is low whenever `busy` is high.
- R6: In the byte-parallel variant, the folded result appears in the cycle after acceptance, `busy` is never high, and `in_ready` is high whenever `init` is low.
- R7: A byte held valid while `in_ready` is low is not taken. It is taken exactly once, at the first edge where `in_ready` is high.
- R8: When `busy` is low and there is neither an `init` nor an accepted byte, `crc_out` keeps its value.
- R9: In the bit-serial variant, `init` during a busy period abandons the byte in progress. `busy` drops in the next cycle, and the checksum holds the chosen seed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Byte on `in_data` is offered |
| in_ready | output | 1 | Engine can take a byte this cycle |
| in_data | input | 8 | Byte to fold into the checksum |
| init | input | 1 | Load the seed this cycle (wins over a byte) |
| init_seed_ones | input | 1 | Seed select: 1 = 0xFFFF, 0 = 0x0000 |
| crc_out | output | 16 | Current checksum value |
| busy | output | 1 | Serial variant still working on a byte |

## Verification
A wrong bit in the running checksum shows up on `crc_out` as soon as the byte in progress finishes. That is one cycle after acceptance in the parallel variant and nine cycles after it in the serial variant. The error is never washed out, because every later byte depends on it. A bad step counter shows up immediately at the ports: `busy` or `in_ready` fall on the wrong cycle, or a held byte is taken twice. The bench compares both variants against a behavioural model on every clock, so these faults are reported within a single byte time.

// File: rtl/crc16_pkg.sv
package crc16_pkg;
  typedef enum logic {
    SEED_ZERO = 1'b0,
    SEED_ONES = 1'b1
  } seed_e;
endpackage

// File: rtl/crc16_step.sv
// One MSB-first division step: shift left, fold in the generator on carry-out.
module crc16_step #(
  parameter int          CRC_W = 16,
  parameter logic [15:0] POLY  = 16'h1021
) (
  input  logic [CRC_W-1:0] crc_in,
  output logic [CRC_W-1:0] crc_nx
);
  localparam logic [CRC_W-1:0] GEN = CRC_W'(POLY);

  always_comb begin
    crc_nx = {crc_in[CRC_W-2:0], 1'b0};
    if (crc_in[CRC_W-1]) crc_nx = crc_nx ^ GEN;
  end
endmodule

// File: rtl/crc16_fold.sv
// Unrolled chain of DATA_W steps: a whole byte per clock.
module crc16_fold #(
  parameter int          CRC_W  = 16,
  parameter int          DATA_W = 8,
  parameter logic [15:0] POLY   = 16'h1021
) (
  input  logic [CRC_W-1:0] mixed_in,
  output logic [CRC_W-1:0] folded
);
  logic [CRC_W-1:0] chain [DATA_W+1];

  assign chain[0] = mixed_in;

  for (genvar g = 0; g < DATA_W; g++) begin : g_stage
    crc16_step #(.CRC_W(CRC_W), .POLY(POLY)) u_step (
      .crc_in (chain[g]),
      .crc_nx (chain[g+1])
    );
  end

  assign folded = chain[DATA_W];
endmodule

// File: rtl/crc16_serial_ctl.sv
// Bit counter for the serial variant: DATA_W busy cycles per accepted byte.
module crc16_serial_ctl #(
  parameter int DATA_W = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic init,
  input  logic start,
  output logic busy
);
  localparam int CW = $clog2(DATA_W + 1);

  logic [CW-1:0] left_q;

  always_ff @(posedge clk) begin
    if (rst || init)         left_q <= '0;
    else if (start)          left_q <= CW'(DATA_W);
    else if (left_q != '0)   left_q <= left_q - 1'b1;
  end

  assign busy = (left_q != '0);
endmodule

// File: rtl/crc16_accum.sv
module crc16_accum
  import crc16_pkg::*;
#(
  parameter int          CRC_W  = 16,
  parameter int          DATA_W = 8,
  parameter logic [15:0] POLY   = 16'h1021,
  parameter bit          SERIAL = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_data,
  input  logic              init,
  input  logic              init_seed_ones,
  output logic [CRC_W-1:0]  crc_out,
  output logic              busy
);
  localparam int PAD = CRC_W - DATA_W;

  logic [CRC_W-1:0] crc_q;
  logic [CRC_W-1:0] crc_d;
  logic [CRC_W-1:0] seed_val;
  logic [CRC_W-1:0] mixed;
  logic             busy_w;
  logic             accept;

  assign in_ready = !busy_w && !init;
  assign accept   = in_valid && in_ready;
  assign seed_val = (seed_e'(init_seed_ones) == SEED_ONES) ? '1 : '0;
  assign mixed    = crc_q ^ {in_data, {PAD{1'b0}}};

  if (SERIAL) begin : g_serial
    logic [CRC_W-1:0] step_nx;

    crc16_serial_ctl #(.DATA_W(DATA_W)) u_ctl (
      .clk   (clk),
      .rst   (rst),
      .init  (init),
      .start (accept),
      .busy  (busy_w)
    );

    crc16_step #(.CRC_W(CRC_W), .POLY(POLY)) u_step (
      .crc_in (crc_q),
      .crc_nx (step_nx)
    );

    always_comb begin
      if (init)        crc_d = seed_val;
      else if (accept) crc_d = mixed;
      else if (busy_w) crc_d = step_nx;
      else             crc_d = crc_q;
    end
  end else begin : g_parallel
    logic [CRC_W-1:0] folded;

    crc16_fold #(.CRC_W(CRC_W), .DATA_W(DATA_W), .POLY(POLY)) u_fold (
      .mixed_in (mixed),
      .folded   (folded)
    );

    assign busy_w = 1'b0;

    always_comb begin
      if (init)        crc_d = seed_val;
      else if (accept) crc_d = folded;
      else             crc_d = crc_q;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) crc_q <= '1;
    else     crc_q <= crc_d;
  end

  assign crc_out = crc_q;
  assign busy    = busy_w;
endmodule

// File: rtl/crc16_accum_chk.sv
module crc16_accum_chk #(
  parameter int CRC_W  = 16,
  parameter bit SERIAL = 1'b1
) (
  input logic             clk,
  input logic             rst,
  input logic             in_valid,
  input logic             in_ready,
  input logic             init,
  input logic             init_seed_ones,
  input logic [CRC_W-1:0] crc_out,
  input logic             busy
);
  assert_reset_state_R1: assert property (@(posedge clk)
    rst |=> (crc_out == {CRC_W{1'b1}} && !busy));

  assert_seed_ones_R2: assert property (@(posedge clk) disable iff (rst)
    (init && init_seed_ones) |=> crc_out == {CRC_W{1'b1}});

  assert_seed_zero_R2: assert property (@(posedge clk) disable iff (rst)
    (init && !init_seed_ones) |=> crc_out == '0);

  assert_init_blocks_R2: assert property (@(posedge clk) disable iff (rst)
    init |-> !in_ready);

  assert_hold_idle_R8: assert property (@(posedge clk) disable iff (rst)
    (!busy && !init && !(in_valid && in_ready)) |=> $stable(crc_out));

  if (SERIAL) begin : g_ser
    logic [7:0] run_q;
    always_ff @(posedge clk) begin
      if (rst || !busy) run_q <= '0;
      else              run_q <= run_q + 1'b1;
    end

    assert_ready_low_R5: assert property (@(posedge clk) disable iff (rst)
      busy |-> !in_ready);

    assert_accept_busy_R5: assert property (@(posedge clk) disable iff (rst)
      (in_valid && in_ready) |=> busy);

    assert_busy_keep_R5: assert property (@(posedge clk) disable iff (rst)
      (busy && !init && run_q < 8'd7) |=> busy);

    assert_busy_end_R5: assert property (@(posedge clk) disable iff (rst)
      (busy && run_q == 8'd7) |=> !busy);

    assert_init_abort_R9: assert property (@(posedge clk) disable iff (rst)
      init |=> !busy);
  end else begin : g_par
    assert_never_busy_R6: assert property (@(posedge clk) disable iff (rst)
      !busy);

    assert_ready_free_R6: assert property (@(posedge clk) disable iff (rst)
      !init |-> in_ready);
  end
endmodule

bind crc16_accum crc16_accum_chk #(.CRC_W(CRC_W), .SERIAL(SERIAL)) u_chk (
  .clk            (clk),
  .rst            (rst),
  .in_valid       (in_valid),
  .in_ready       (in_ready),
  .init           (init),
  .init_seed_ones (init_seed_ones),
  .crc_out        (crc_out),
  .busy           (busy)
);

// File: tb/test_crc16_accum.sv
module test_crc16_accum;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic vs = 1'b0, vp = 1'b0;
  logic init = 1'b0, seed1 = 1'b1;
  logic [7:0] data = '0;
  logic rdy_s, rdy_p, busy_s, busy_p;
  logic [15:0] crc_s, crc_p;

  int checks = 0, failures = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  crc16_accum #(.SERIAL(1'b1)) i_crc16_accum (
    .clk(clk), .rst(rst), .in_valid(vs), .in_ready(rdy_s), .in_data(data),
    .init(init), .init_seed_ones(seed1), .crc_out(crc_s), .busy(busy_s));

  crc16_accum #(.SERIAL(1'b0)) i_crc16_accum_par (
    .clk(clk), .rst(rst), .in_valid(vp), .in_ready(rdy_p), .in_data(data),
    .init(init), .init_seed_ones(seed1), .crc_out(crc_p), .busy(busy_p));

  // Behavioural checksum of one byte, bit by bit
  function automatic int fold_byte(int c, int b);
    int r = (c ^ (b << 8)) & 'hFFFF;
    for (int i = 0; i < 8; i++) begin
      if ((r & 'h8000) != 0) r = ((r << 1) ^ 'h1021) & 'hFFFF;
      else                   r = (r << 1) & 'hFFFF;
    end
    return r;
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h at %0t", req, act, exp, $time);
    end
  endtask

  // Reference model, updated on every clock
  int m_crc_s = 'hFFFF, m_pend = 0, m_cnt = 0, m_crc_p = 'hFFFF;
  always @(posedge clk) begin
    if (rst) begin
      m_crc_s = 'hFFFF; m_cnt = 0; m_crc_p = 'hFFFF;
    end else if (init) begin
      m_crc_s = seed1 ? 'hFFFF : 0; m_cnt = 0;
      m_crc_p = seed1 ? 'hFFFF : 0;
    end else begin
      if (vs && m_cnt == 0) begin
        m_pend = fold_byte(m_crc_s, data); m_cnt = 8;
      end else if (m_cnt > 0) begin
        m_cnt--;
        if (m_cnt == 0) m_crc_s = m_pend;
      end
      if (vp) m_crc_p = fold_byte(m_crc_p, data);
    end
  end

  // Per-clock comparison away from the active edge
  always @(negedge clk) begin
    if (!rst && !done) begin
      chk(busy_s == (m_cnt != 0), "R5 serial busy", busy_s, m_cnt != 0);
      chk(rdy_s == (m_cnt == 0 && !init), "R7 serial ready", rdy_s, m_cnt == 0 && !init);
      if (m_cnt == 0) chk(crc_s == m_crc_s[15:0], "R3 serial crc", crc_s, m_crc_s);
      chk(busy_p == 1'b0, "R6 parallel busy", busy_p, 0);
      chk(rdy_p == !init, "R6 parallel ready", rdy_p, !init);
      chk(crc_p == m_crc_p[15:0], "R3 parallel crc", crc_p, m_crc_p);
    end
  end

  task automatic feed(input logic [7:0] b);
    bit as, ap;
    data = b; vs = 1'b1; vp = 1'b1;
    while (vs || vp) begin
      @(negedge clk);
      as = vs && rdy_s;
      ap = vp && rdy_p;
      @(posedge clk); #1;
      if (as) vs = 1'b0;
      if (ap) vp = 1'b0;
    end
  endtask

  task automatic wait_idle();
    @(negedge clk);
    while (busy_s) @(negedge clk);
  endtask

  task automatic do_init(input logic ones);
    init = 1'b1; seed1 = ones;
    @(posedge clk); #1;
    init = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int lfsr = 'h5A;
    int exp_v;
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    @(negedge clk);
    chk(crc_s == 16'hFFFF, "R1 reset crc", crc_s, 'hFFFF);
    chk(!busy_s && rdy_s, "R1 reset busy/ready", {busy_s, rdy_s}, 1);
    @(posedge clk); #1;

    // R4 known answers
    do_init(1'b1); feed(8'h63); wait_idle();
    chk(crc_s == 16'hBD35, "R4 0x63 serial", crc_s, 'hBD35);
    chk(crc_p == 16'hBD35, "R4 0x63 parallel", crc_p, 'hBD35);

    @(posedge clk); #1;
    do_init(1'b1); feed(8'hAA); feed(8'hBB); feed(8'hCC); wait_idle();
    chk(crc_s == 16'h6CF6, "R4 AA BB CC serial", crc_s, 'h6CF6);
    chk(crc_p == 16'h6CF6, "R4 AA BB CC parallel", crc_p, 'h6CF6);

    @(posedge clk); #1;
    do_init(1'b1);
    feed(8'h00); feed(8'h00); feed(8'hAA); feed(8'hBB); feed(8'hCC); wait_idle();
    chk(crc_s == 16'hB166, "R4 five-byte serial", crc_s, 'hB166);
    chk(crc_p == 16'hB166, "R4 five-byte parallel", crc_p, 'hB166);

    // R2 zero seed, then R3 on a zero-seeded byte
    @(posedge clk); #1;
    do_init(1'b0);
    @(negedge clk);
    chk(crc_s == 16'h0000 && crc_p == 16'h0000, "R2 zero seed", crc_s, 0);
    @(posedge clk); #1;
    feed(8'h63); wait_idle();
    exp_v = fold_byte(0, 'h63);
    chk(crc_s == exp_v[15:0], "R3 zero-seed byte", crc_s, exp_v);

    // R2 init wins over a byte offered in the same cycle
    @(posedge clk); #1;
    data = 8'h55; vs = 1'b1; vp = 1'b1; init = 1'b1; seed1 = 1'b1;
    @(posedge clk); #1;
    vs = 1'b0; vp = 1'b0; init = 1'b0;
    @(negedge clk);
    chk(crc_s == 16'hFFFF && crc_p == 16'hFFFF, "R2 init priority", crc_p, 'hFFFF);
    chk(!busy_s, "R2 no byte taken", busy_s, 0);

    // R9 init aborts serial byte in progress
    @(posedge clk); #1;
    feed(8'hA5);
    repeat (3) @(posedge clk); #1;
    do_init(1'b0);
    @(negedge clk);
    chk(!busy_s, "R9 busy cleared", busy_s, 0);
    chk(crc_s == 16'h0000, "R9 seed loaded", crc_s, 0);

    // R8 hold with nothing offered
    @(posedge clk); #1;
    repeat (5) @(posedge clk);
    @(negedge clk);
    chk(crc_s == 16'h0000 && crc_p == 16'h0000, "R8 idle hold", crc_s, 0);

    // R7 back-to-back held bytes, pseudo-random stream
    @(posedge clk); #1;
    do_init(1'b1);
    for (int k = 0; k < 40; k++) begin
      lfsr = ((lfsr << 1) ^ (((lfsr >> 7) ^ (lfsr >> 5)) & 1)) & 'hFF;
      feed(lfsr[7:0]);
    end
    wait_idle();
    chk(crc_s == crc_p, "R7 variants agree", crc_s, crc_p);

    repeat (2) @(posedge clk);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule